// File: doc/BRIEF.md
# Single-Cycle Processor Control Decoder

This block is the main control decoder of a single-cycle processor datapath. It takes the 6-bit primary opcode and the 6-bit function field of the instruction being executed and, in the same cycle and with no state of its own, produces every steering and enable signal the datapath needs. These are the register-file write enable, the data-memory write enable, the destination-register select, the ALU second-operand select, the write-back source select, the immediate-extension mode, the branch and jump selects for the next-PC logic, and a 2-bit ALU operation code.

Seven instructions are decoded: register add, register subtract, OR with a zero-extended immediate, word load, word store, branch-if-equal and jump. Each instruction is matched as one exact minterm of the opcode, and the two register forms also need an exact function value. The control outputs are then formed as ORs of those minterms. Any encoding that matches no minterm leaves the processor state alone.

Top module: `sc_ctrl_decoder`

## Requirements
- R1: Opcode 000000 with function 100000 (add) drives o_dst_rd=1, o_rf_we=1, o_alu_op=00 (ADD) and every other output 0.
- R2: Opcode 000000 with function 100010 (subtract) drives o_dst_rd=1, o_rf_we=1, o_alu_op=01 (SUB) and every other output 0.
- R3: Opcode 001101 (OR-immediate) drives o_rf_we=1, o_b_from_imm=1, o_ext_signed=0 (zero-extend), o_alu_op=10 (OR) and every other output 0.
- R4: Opcode 100011 (load) drives o_rf_we=1, o_b_from_imm=1, o_wb_from_mem=1, o_ext_signed=1 (sign-extend), o_alu_op=00 and every other output 0.
- R5: Opcode 101011 (store) drives o_dm_we=1, o_b_from_imm=1, o_ext_signed=1, o_alu_op=00 and every other output 0.
- R6: Opcode 000100 (branch-if-equal) drives o_branch_sel=1 and o_alu_op=01 (SUB, equality seen as a zero result), with every other output 0.
- R7: Opcode 000010 (jump) drives o_jump=1 with every other output 0, including o_alu_op=00.
- R8: Any opcode outside the six above, or opcode 000000 with a function other than 100000 or 100010, drives every output to 0, so no register, memory, branch or jump effect occurs.
- R9: For every input encoding, at most one of o_rf_we, o_dm_we, o_branch_sel and o_jump is 1.
- R10: For every opcode other than 000000, the outputs do not depend on the function field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| i_opcode | input | 6 | Primary opcode field of the instruction |
| i_funct | input | 6 | Function field, used only with opcode 000000 |
| o_dst_rd | output | 1 | 1 selects the rd field as write register, 0 selects rt |
| o_b_from_imm | output | 1 | 1 feeds the extended immediate to the ALU B input, 0 the second register |
| o_wb_from_mem | output | 1 | 1 writes back data-memory output, 0 writes back the ALU result |
| o_rf_we | output | 1 | Register-file write enable |
| o_dm_we | output | 1 | Data-memory write enable |
| o_branch_sel | output | 1 | Next-PC takes the branch target when the ALU result is zero |
| o_jump | output | 1 | Next-PC takes the jump target |
| o_ext_signed | output | 1 | 1 sign-extends the 16-bit immediate, 0 zero-extends it |
| o_alu_op | output | 2 | ALU operation: 00 ADD, 01 SUB, 10 OR |

## Verification
The behaviour hardest to reach from the ports is the near miss: an encoding one bit away from a supported minterm, above all an opcode-000000 word whose function differs from add or subtract in a single bit. Such a word must decode as fully quiet and not as a partial add. The stimulus sweeps all 4096 opcode and function pairs, so every near miss in either field is applied. Each result is compared with a value computed from the instruction table, and each non-register opcode is also checked for identical outputs across all 64 function values.

// File: rtl/scd_pkg.sv
package scd_pkg;

    localparam int OPC_W     = 6;
    localparam int FN_W      = 6;
    localparam int NUM_INSTR = 7;
    localparam int ALU_W     = 2;

    // Instruction slot indices in the one-hot match vector
    localparam int IX_ADD = 0;
    localparam int IX_SUB = 1;
    localparam int IX_ORI = 2;
    localparam int IX_LD  = 3;
    localparam int IX_ST  = 4;
    localparam int IX_BEQ = 5;
    localparam int IX_JMP = 6;

    localparam logic [OPC_W-1:0] OPC_REG  = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_ORI  = 6'b001101;
    localparam logic [OPC_W-1:0] OPC_LD   = 6'b100011;
    localparam logic [OPC_W-1:0] OPC_ST   = 6'b101011;
    localparam logic [OPC_W-1:0] OPC_BEQ  = 6'b000100;
    localparam logic [OPC_W-1:0] OPC_JMP  = 6'b000010;

    localparam logic [FN_W-1:0]  FN_ADD   = 6'b100000;
    localparam logic [FN_W-1:0]  FN_SUB   = 6'b100010;

    typedef enum logic [ALU_W-1:0] {
        ALU_ADD = 2'b00,
        ALU_SUB = 2'b01,
        ALU_OR  = 2'b10
    } alu_op_e;

    typedef logic [NUM_INSTR-1:0] instr_hot_t;

    typedef struct packed {
        logic    dst_rd;
        logic    b_from_imm;
        logic    wb_from_mem;
        logic    rf_we;
        logic    dm_we;
        logic    branch_sel;
        logic    jump;
        logic    ext_signed;
        alu_op_e alu_op;
    } ctrl_word_t;

    function automatic logic [OPC_W-1:0] instr_opcode(input int ix);
        case (ix)
            IX_ADD, IX_SUB: return OPC_REG;
            IX_ORI:         return OPC_ORI;
            IX_LD:          return OPC_LD;
            IX_ST:          return OPC_ST;
            IX_BEQ:         return OPC_BEQ;
            default:        return OPC_JMP;
        endcase
    endfunction

    function automatic logic instr_needs_funct(input int ix);
        return (ix == IX_ADD) || (ix == IX_SUB);
    endfunction

    function automatic logic [FN_W-1:0] instr_funct(input int ix);
        return (ix == IX_SUB) ? FN_SUB : FN_ADD;
    endfunction

    function automatic instr_hot_t slot(input int ix);
        instr_hot_t v;
        v = '0;
        v[ix] = 1'b1;
        return v;
    endfunction

    // OR-plane column masks: which instructions raise each control
    localparam instr_hot_t M_DST_RD   = slot(IX_ADD) | slot(IX_SUB);
    localparam instr_hot_t M_B_IMM    = slot(IX_ORI) | slot(IX_LD) | slot(IX_ST);
    localparam instr_hot_t M_WB_MEM   = slot(IX_LD);
    localparam instr_hot_t M_RF_WE    = slot(IX_ADD) | slot(IX_SUB) | slot(IX_ORI) | slot(IX_LD);
    localparam instr_hot_t M_DM_WE    = slot(IX_ST);
    localparam instr_hot_t M_BRANCH   = slot(IX_BEQ);
    localparam instr_hot_t M_JUMP     = slot(IX_JMP);
    localparam instr_hot_t M_EXT_SGN  = slot(IX_LD) | slot(IX_ST);
    localparam instr_hot_t M_ALU_B0   = slot(IX_SUB) | slot(IX_BEQ);
    localparam instr_hot_t M_ALU_B1   = slot(IX_ORI);

    function automatic logic any_of(input instr_hot_t hit, input instr_hot_t mask);
        return |(hit & mask);
    endfunction

endpackage

// File: rtl/scd_match_plane.sv
module scd_match_plane
    import scd_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    input  logic [FN_W-1:0]  funct,
    output instr_hot_t       hit
);

    for (genvar g = 0; g < NUM_INSTR; g++) begin : g_term
        localparam logic [OPC_W-1:0] TERM_OPC = instr_opcode(g);
        if (instr_needs_funct(g)) begin : g_with_fn
            localparam logic [FN_W-1:0] TERM_FN = instr_funct(g);
            assign hit[g] = (opcode == TERM_OPC) && (funct == TERM_FN);
        end else begin : g_opc_only
            assign hit[g] = (opcode == TERM_OPC);
        end
    end

endmodule

// File: rtl/scd_or_plane.sv
module scd_or_plane
    import scd_pkg::*;
(
    input  instr_hot_t hit,
    output ctrl_word_t word
);

    logic [ALU_W-1:0] alu_bits;

    always_comb begin
        alu_bits         = {any_of(hit, M_ALU_B1), any_of(hit, M_ALU_B0)};
        word.dst_rd      = any_of(hit, M_DST_RD);
        word.b_from_imm  = any_of(hit, M_B_IMM);
        word.wb_from_mem = any_of(hit, M_WB_MEM);
        word.rf_we       = any_of(hit, M_RF_WE);
        word.dm_we       = any_of(hit, M_DM_WE);
        word.branch_sel  = any_of(hit, M_BRANCH);
        word.jump        = any_of(hit, M_JUMP);
        word.ext_signed  = any_of(hit, M_EXT_SGN);
        word.alu_op      = alu_op_e'(alu_bits);
    end

endmodule

// File: rtl/sc_ctrl_decoder.sv
module sc_ctrl_decoder
    import scd_pkg::*;
(
    input  logic [5:0] i_opcode,
    input  logic [5:0] i_funct,
    output logic       o_dst_rd,
    output logic       o_b_from_imm,
    output logic       o_wb_from_mem,
    output logic       o_rf_we,
    output logic       o_dm_we,
    output logic       o_branch_sel,
    output logic       o_jump,
    output logic       o_ext_signed,
    output logic [1:0] o_alu_op
);

    instr_hot_t hit;
    ctrl_word_t word;

    scd_match_plane u_match (
        .opcode (i_opcode),
        .funct  (i_funct),
        .hit    (hit)
    );

    scd_or_plane u_or (
        .hit  (hit),
        .word (word)
    );

    assign o_dst_rd      = word.dst_rd;
    assign o_b_from_imm  = word.b_from_imm;
    assign o_wb_from_mem = word.wb_from_mem;
    assign o_rf_we       = word.rf_we;
    assign o_dm_we       = word.dm_we;
    assign o_branch_sel  = word.branch_sel;
    assign o_jump        = word.jump;
    assign o_ext_signed  = word.ext_signed;
    assign o_alu_op      = word.alu_op;

endmodule

// File: rtl/sc_ctrl_decoder_chk.sv
module sc_ctrl_decoder_chk (
    input logic [5:0] i_opcode,
    input logic [5:0] i_funct,
    input logic       o_dst_rd,
    input logic       o_b_from_imm,
    input logic       o_wb_from_mem,
    input logic       o_rf_we,
    input logic       o_dm_we,
    input logic       o_branch_sel,
    input logic       o_jump,
    input logic       o_ext_signed,
    input logic [1:0] o_alu_op
);

    logic known_opc;
    logic reg_ok;

    always_comb begin
        known_opc = (i_opcode == 6'b000000) || (i_opcode == 6'b001101) ||
                    (i_opcode == 6'b100011) || (i_opcode == 6'b101011) ||
                    (i_opcode == 6'b000100) || (i_opcode == 6'b000010);
        reg_ok    = (i_funct == 6'b100000) || (i_funct == 6'b100010);

        // R9: one architectural effect at most
        a_r9_single_effect: assert ($onehot0({o_rf_we, o_dm_we, o_branch_sel, o_jump}));

        // R8: unknown opcode leaves everything quiet
        if (!known_opc || (i_opcode == 6'b000000 && !reg_ok)) begin
            a_r8_unknown_quiet: assert ({o_dst_rd, o_b_from_imm, o_wb_from_mem, o_rf_we,
                                         o_dm_we, o_branch_sel, o_jump, o_ext_signed,
                                         o_alu_op} == 10'b0);
        end

        // R1, R2: rd destination only for the register forms
        if (o_dst_rd) begin
            a_r1_r2_rd_only_regform: assert (i_opcode == 6'b000000 && reg_ok && o_rf_we);
        end

        // R6: branch compares by subtracting
        if (o_branch_sel) begin
            a_r6_branch_uses_sub: assert (o_alu_op == 2'b01 && i_opcode == 6'b000100);
        end

        // R4: memory write-back implies sign-extended address and a register write
        if (o_wb_from_mem) begin
            a_r4_load_path: assert (o_rf_we && o_ext_signed && o_b_from_imm && o_alu_op == 2'b00);
        end

        // R5: a memory write never writes a register
        if (o_dm_we) begin
            a_r5_store_path: assert (!o_rf_we && o_ext_signed && i_opcode == 6'b101011);
        end

        // R3: OR operation only with a zero-extended immediate
        if (o_alu_op == 2'b10) begin
            a_r3_or_zero_ext: assert (!o_ext_signed && o_b_from_imm && i_opcode == 6'b001101);
        end

        // R7: jump touches nothing else
        if (o_jump) begin
            a_r7_jump_alone: assert (o_alu_op == 2'b00 && !o_b_from_imm && !o_dst_rd);
        end
    end

endmodule

bind sc_ctrl_decoder sc_ctrl_decoder_chk i_chk (
    .i_opcode      (i_opcode),
    .i_funct       (i_funct),
    .o_dst_rd      (o_dst_rd),
    .o_b_from_imm  (o_b_from_imm),
    .o_wb_from_mem (o_wb_from_mem),
    .o_rf_we       (o_rf_we),
    .o_dm_we       (o_dm_we),
    .o_branch_sel  (o_branch_sel),
    .o_jump        (o_jump),
    .o_ext_signed  (o_ext_signed),
    .o_alu_op      (o_alu_op)
);

// File: tb/test_sc_ctrl_decoder.sv
module test_sc_ctrl_decoder;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = '0;
    logic [5:0] funct  = '0;
    logic       dst_rd, b_imm, wb_mem, rf_we, dm_we, br_sel, jmp, ext_sgn;
    logic [1:0] alu_op;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    sc_ctrl_decoder i_sc_ctrl_decoder (
        .i_opcode      (opcode),
        .i_funct       (funct),
        .o_dst_rd      (dst_rd),
        .o_b_from_imm  (b_imm),
        .o_wb_from_mem (wb_mem),
        .o_rf_we       (rf_we),
        .o_dm_we       (dm_we),
        .o_branch_sel  (br_sel),
        .o_jump        (jmp),
        .o_ext_signed  (ext_sgn),
        .o_alu_op      (alu_op)
    );

    // Packed order: dst_rd, b_imm, wb_mem, rf_we, dm_we, br_sel, jmp, ext_sgn, alu_op[1:0]
    function automatic logic [9:0] expect_word(input logic [5:0] op, input logic [5:0] fn,
                                               output string tag);
        case (op)
            6'b000000: begin
                if (fn == 6'b100000) begin tag = "R1"; return 10'b1001000000; end
                else if (fn == 6'b100010) begin tag = "R2"; return 10'b1001000001; end
                else begin tag = "R8"; return 10'b0; end
            end
            6'b001101: begin tag = "R3"; return 10'b0101000010; end
            6'b100011: begin tag = "R4"; return 10'b0111000100; end
            6'b101011: begin tag = "R5"; return 10'b0100100100; end
            6'b000100: begin tag = "R6"; return 10'b0000010001; end
            6'b000010: begin tag = "R7"; return 10'b0000001000; end
            default:   begin tag = "R8"; return 10'b0; end
        endcase
    endfunction

    function automatic logic [9:0] actual_word();
        return {dst_rd, b_imm, wb_mem, rf_we, dm_we, br_sel, jmp, ext_sgn, alu_op};
    endfunction

    task automatic check(input string tag, input logic [9:0] got, input logic [9:0] exp,
                         input logic [5:0] op, input logic [5:0] fn);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s op=%b fn=%b actual=%b expected=%b", tag, op, fn, got, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        repeat (2000000 / 20) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [9:0] ref_word;
        logic [9:0] exp;
        logic [9:0] got;
        string      tag;

        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: reset-time inputs (opcode 000000, funct 000000) are an unsupported pair
        check("R8", actual_word(), 10'b0, opcode, funct);

        for (int op = 0; op < 64; op++) begin
            ref_word = '0;
            for (int fn = 0; fn < 64; fn++) begin
                @(posedge clk);
                opcode <= 6'(op);
                funct  <= 6'(fn);
                @(negedge clk);
                got = actual_word();
                exp = expect_word(6'(op), 6'(fn), tag);
                check(tag, got, exp, 6'(op), 6'(fn));
                // R9: at most one of rf_we, dm_we, br_sel, jmp
                check("R9", {9'b0, ($countones({rf_we, dm_we, br_sel, jmp}) <= 1)},
                      10'b1, 6'(op), 6'(fn));
                // R10: non-register opcodes ignore the function field
                if (op != 0) begin
                    if (fn == 0) ref_word = got;
                    else check("R10", got, ref_word, 6'(op), 6'(fn));
                end
            end
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule